// File: doc/BRIEF.md
# Segment Selection Resolver

This block decides which segment register governs a memory operand. It looks at five things: the first opcode byte and its length, a one-hot set of segment-override prefix flags that an upstream decoder has already found, a code for the operand's base register, the address size and a long-mode flag. From these it produces a 3-bit segment index and a separate error flag.

The block has three inputs to its rules. String instructions pin the destination index register to ES and ignore any overrides on it. Two or more overrides make an error. In long mode the defaults collapse to IGNORE, and only an FS or GS override survives.

The parameter `REGISTERED` chooses the output timing. When it is 1, a strobe captures the inputs and the result appears one clock later with a one-cycle done pulse. When it is 0, the result is purely combinational and done follows the strobe.

Top module: `segsel_resolve`

## Requirements
- R1: An instruction is a string instruction only when `opc_len` is 1 and `opcode` lies in 0x6C..0x6F, 0xA4..0xA7 or 0xAA..0xAF. With any other length the same byte is not a string instruction.
- R2: When two or more bits of `ovr_mask` are set, `out_err` is 1. This does not apply when the base register is the instruction pointer, or the destination index in a string instruction. Mask bits: bit0 ES, bit1 CS, bit2 SS, bit3 DS, bit4 FS, bit5 GS.
- R3: When `base_reg` is DI (7) and the instruction is a string instruction, all overrides are ignored. The result is ES, or IGNORE in long mode, with no error.
- R4: With no override, outside long mode, the defaults are as follows. AX(0), CX(1), DX(2), BX(3), SI(6) and displacement-only (9) give DS. SP(4) and BP(5) give SS. DI outside a string instruction gives DS. Segment codes: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5, IGNORE=7.
- R5: Outside long mode, when there is no override, AX, CX or DX with 16-bit address size (`addr_size`=0) gives an error. The 32-bit (1) and 64-bit (2) sizes give no error.
- R6: When `base_reg` is the instruction pointer (8), the result is CS outside long mode and IGNORE in long mode. It is never an error, whatever the prefixes.
- R7: In long mode, a default resolves to IGNORE. A single override is passed through only if it is FS or GS. Any other single override gives IGNORE.
- R8: A `base_reg` value from 10 to 15 gives an error.
- R9: Outside long mode, a single override (other than on a string DI operand) selects the segment it names.
- R10: Whenever `out_err` is 1, `out_seg` reads IGNORE.
- R11: In the registered variant, a strobe on `in_valid` produces the result and a one-cycle `out_done` on the next clock. The outputs hold until the next strobe. After reset, `out_done`=0, `out_err`=0 and `out_seg`=IGNORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 8 | First opcode byte |
| opc_len | input | OPC_LEN_W | Opcode length in bytes |
| ovr_mask | input | 6 | One-hot-per-segment override prefix flags |
| base_reg | input | 4 | Operand base register code |
| addr_size | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit |
| long_mode | input | 1 | 64-bit mode flag |
| out_done | output | 1 | Result valid pulse |
| out_seg | output | 3 | Resolved segment index |
| out_err | output | 1 | Resolution error |

## Verification
The assertions assume that the inputs stay steady only while the strobe is sampled. They relate each result to the inputs one cycle earlier, so they make no assumption about encodings beyond the 4-bit register code and the 6-bit mask. The stimulus covers every register code, including the invalid ones, and any mask pattern. It biases opcodes toward the string ranges and their edges. It drives new inputs only on the falling edge, one strobe every other cycle.

// File: rtl/segsel_pkg.sv
package segsel_pkg;
   localparam int SEG_W   = 3;
   localparam int MASK_W  = 6;
   localparam int RCODE_W = 4;

   typedef enum logic [SEG_W-1:0] {
      SEG_ES   = 3'd0,
      SEG_CS   = 3'd1,
      SEG_SS   = 3'd2,
      SEG_DS   = 3'd3,
      SEG_FS   = 3'd4,
      SEG_GS   = 3'd5,
      SEG_NONE = 3'd7
   } seg_e;

   localparam logic [RCODE_W-1:0] RC_AX   = 4'd0;
   localparam logic [RCODE_W-1:0] RC_CX   = 4'd1;
   localparam logic [RCODE_W-1:0] RC_DX   = 4'd2;
   localparam logic [RCODE_W-1:0] RC_BX   = 4'd3;
   localparam logic [RCODE_W-1:0] RC_SP   = 4'd4;
   localparam logic [RCODE_W-1:0] RC_BP   = 4'd5;
   localparam logic [RCODE_W-1:0] RC_SI   = 4'd6;
   localparam logic [RCODE_W-1:0] RC_DI   = 4'd7;
   localparam logic [RCODE_W-1:0] RC_IP   = 4'd8;
   localparam logic [RCODE_W-1:0] RC_DISP = 4'd9;

   localparam logic [1:0] ASZ_16 = 2'd0;
endpackage

// File: rtl/segsel_strdet.sv
module segsel_strdet #(
   parameter int OPC_LEN_W = 3
) (
   input  logic [7:0]           opcode,
   input  logic [OPC_LEN_W-1:0] opc_len,
   output logic                 is_str
);
   localparam logic [OPC_LEN_W-1:0] ONE_BYTE = OPC_LEN_W'(1);

   logic in_io_blk, in_mv_blk, in_ld_blk;

   always_comb begin
      in_io_blk = (opcode[7:2] == 6'b011011);
      in_mv_blk = (opcode[7:2] == 6'b101001);
      in_ld_blk = (opcode >= 8'hAA) && (opcode <= 8'hAF);
      is_str    = (opc_len == ONE_BYTE) && (in_io_blk || in_mv_blk || in_ld_blk);
   end
endmodule

// File: rtl/segsel_ovr.sv
module segsel_ovr
   import segsel_pkg::*;
#(
   parameter int N = MASK_W
) (
   input  logic [N-1:0]     mask,
   output logic             any,
   output logic             multi,
   output logic [SEG_W-1:0] idx
);
   localparam int CNT_W = $clog2(N + 1);

   logic [CNT_W-1:0] cnt;

   always_comb begin
      cnt = '0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         cnt = cnt + CNT_W'(mask[i]);
         if (mask[i]) idx = idx | SEG_W'(i);
      end
      any   = (cnt != '0);
      multi = (cnt > CNT_W'(1));
   end
endmodule

// File: rtl/segsel_dflt.sv
module segsel_dflt
   import segsel_pkg::*;
(
   input  logic [RCODE_W-1:0] rcode,
   input  logic [1:0]         addr_size,
   input  logic               is_str,
   output seg_e               dseg,
   output logic               err16,
   output logic               bad
);
   always_comb begin
      dseg  = SEG_NONE;
      err16 = 1'b0;
      bad   = 1'b0;
      case (rcode)
         RC_AX, RC_CX, RC_DX: begin
            dseg  = SEG_DS;
            err16 = (addr_size == ASZ_16);
         end
         RC_BX, RC_SI, RC_DISP: dseg = SEG_DS;
         RC_DI:                 dseg = is_str ? SEG_ES : SEG_DS;
         RC_SP, RC_BP:          dseg = SEG_SS;
         RC_IP:                 dseg = SEG_CS;
         default:               bad  = 1'b1;
      endcase
   end
endmodule

// File: rtl/segsel_resolve.sv
module segsel_resolve
   import segsel_pkg::*;
#(
   parameter int OPC_LEN_W  = 3,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [7:0]           opcode,
   input  logic [OPC_LEN_W-1:0] opc_len,
   input  logic [5:0]           ovr_mask,
   input  logic [3:0]           base_reg,
   input  logic [1:0]           addr_size,
   input  logic                 long_mode,
   output logic                 out_done,
   output logic [2:0]           out_seg,
   output logic                 out_err
);
   initial begin
      assert (OPC_LEN_W >= 2) else $error("OPC_LEN_W must be at least 2");
      assert (MASK_W == 6 && SEG_W == 3) else $error("package widths changed");
   end

   logic             is_str, any_ovr, multi_ovr, err16, bad_rc;
   logic [SEG_W-1:0] ovr_idx;
   seg_e             dseg;
   seg_e             res_seg;
   logic             res_err;

   segsel_strdet #(.OPC_LEN_W(OPC_LEN_W)) u_str (
      .opcode (opcode),
      .opc_len(opc_len),
      .is_str (is_str)
   );

   segsel_ovr #(.N(MASK_W)) u_ovr (
      .mask (ovr_mask),
      .any  (any_ovr),
      .multi(multi_ovr),
      .idx  (ovr_idx)
   );

   segsel_dflt u_dflt (
      .rcode    (base_reg),
      .addr_size(addr_size),
      .is_str   (is_str),
      .dseg     (dseg),
      .err16    (err16),
      .bad      (bad_rc)
   );

   always_comb begin
      res_seg = SEG_NONE;
      res_err = 1'b0;
      if (base_reg == RC_IP) begin
         res_seg = long_mode ? SEG_NONE : SEG_CS;
      end else if (bad_rc) begin
         res_err = 1'b1;
      end else if (base_reg == RC_DI && is_str) begin
         res_seg = long_mode ? SEG_NONE : dseg;
      end else if (multi_ovr) begin
         res_err = 1'b1;
      end else if (any_ovr) begin
         if (long_mode && ovr_idx != SEG_FS && ovr_idx != SEG_GS)
            res_seg = SEG_NONE;
         else
            res_seg = seg_e'(ovr_idx);
      end else if (long_mode) begin
         res_seg = SEG_NONE;
      end else if (err16) begin
         res_err = 1'b1;
      end else begin
         res_seg = dseg;
      end
   end

   // R10: error always reports the IGNORE code
   a_r10_err_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_seg == SEG_NONE);

   generate
      if (REGISTERED) begin : g_reg
         logic             done_q, err_q;
         logic [SEG_W-1:0] seg_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               err_q  <= 1'b0;
               seg_q  <= SEG_NONE;
            end else begin
               done_q <= in_valid;
               if (in_valid) begin
                  err_q <= res_err;
                  seg_q <= res_seg;
               end
            end
         end

         assign out_done = done_q;
         assign out_err  = err_q;
         assign out_seg  = seg_q;

         a_r11_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            out_done |-> $past(in_valid));
         a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_seg) && $stable(out_err));
         a_r6_ip_never_err: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && base_reg == RC_IP |=>
               !out_err && out_seg == ($past(long_mode) ? SEG_NONE : SEG_CS));
         a_r8_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && base_reg > RC_DISP |=> out_err);
         a_r7_long_seg: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && long_mode |=>
               out_seg == SEG_NONE || out_seg == SEG_FS || out_seg == SEG_GS);
         a_r2_multi: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && $countones(ovr_mask) > 1 && base_reg != RC_IP &&
            base_reg != RC_DI && base_reg <= RC_DISP |=> out_err);
      end else begin : g_comb
         assign out_done = in_valid;
         assign out_err  = res_err;
         assign out_seg  = res_seg;
      end
   endgenerate
endmodule

// File: tb/sim_segsel_resolve.sv
module sim_segsel_resolve;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] opcode = '0;
   logic [2:0] opc_len = 3'd1;
   logic [5:0] ovr_mask = '0;
   logic [3:0] base_reg = '0;
   logic [1:0] addr_size = 2'd1;
   logic       long_mode = 1'b0;
   logic       out_done, out_err;
   logic [2:0] out_seg;

   int n_run = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   segsel_resolve u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .opc_len(opc_len), .ovr_mask(ovr_mask), .base_reg(base_reg),
      .addr_size(addr_size), .long_mode(long_mode), .out_done(out_done),
      .out_seg(out_seg), .out_err(out_err)
   );

   // returns {err, seg}
   function automatic logic [3:0] expect_res(input logic [7:0] op, input logic [2:0] ln,
         input logic [5:0] m, input logic [3:0] r, input logic [1:0] a, input logic lm);
      bit s;
      int n;
      int idx;
      s = (ln == 3'd1) && ((op >= 8'h6C && op <= 8'h6F) || (op >= 8'hA4 && op <= 8'hA7) ||
                           (op >= 8'hAA && op <= 8'hAF));
      n = $countones(m);
      idx = 0;
      for (int i = 0; i < 6; i++) if (m[i]) idx = i;
      if (r == 4'd8) return {1'b0, lm ? 3'd7 : 3'd1};
      if (r > 4'd9) return {1'b1, 3'd7};
      if (r == 4'd7 && s) return {1'b0, lm ? 3'd7 : 3'd0};
      if (n > 1) return {1'b1, 3'd7};
      if (n == 1) begin
         if (lm && idx != 4 && idx != 5) return {1'b0, 3'd7};
         return {1'b0, 3'(idx)};
      end
      if (lm) return {1'b0, 3'd7};
      case (r)
         4'd0, 4'd1, 4'd2: return (a == 2'd0) ? {1'b1, 3'd7} : {1'b0, 3'd3};
         4'd4, 4'd5:       return {1'b0, 3'd2};
         default:          return {1'b0, 3'd3};
      endcase
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got err=%0b seg=%0d, expected err=%0b seg=%0d",
                  tag, act[3], act[2:0], exp[3], exp[2:0]);
      end
   endtask

   task automatic apply(input string tag, input logic [7:0] op, input logic [2:0] ln,
         input logic [5:0] m, input logic [3:0] r, input logic [1:0] a, input logic lm);
      @(negedge clk);
      opcode = op; opc_len = ln; ovr_mask = m; base_reg = r; addr_size = a; long_mode = lm;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R11 done"}, {3'b0, out_done}, 4'd1);
      check(tag, {out_err, out_seg}, expect_res(op, ln, m, r, a, lm));
   endtask

   initial begin : watchdog
      #4000000;
      n_run++; n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin : stim
      logic [3:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset state", {out_err, out_seg}, {1'b0, 3'd7});
      check("R11 reset done", {3'b0, out_done}, 4'd0);

      apply("R1 string DI -> ES", 8'hA4, 3'd1, 6'b0, 4'd7, 2'd1, 1'b0);
      apply("R1 two-byte not string", 8'hA4, 3'd2, 6'b0, 4'd7, 2'd1, 1'b0);
      apply("R1 edge 0x6B not string", 8'h6B, 3'd1, 6'b0, 4'd7, 2'd1, 1'b0);
      apply("R1 edge 0xAF string", 8'hAF, 3'd1, 6'b0, 4'd7, 2'd1, 1'b0);
      apply("R1 0xA8 not string", 8'hA8, 3'd1, 6'b0, 4'd7, 2'd1, 1'b0);
      apply("R2 two overrides", 8'h8B, 3'd1, 6'b010001, 4'd3, 2'd1, 1'b0);
      apply("R3 string DI ignores multi", 8'hAA, 3'd1, 6'b110000, 4'd7, 2'd1, 1'b0);
      apply("R3 string DI long", 8'h6C, 3'd1, 6'b010000, 4'd7, 2'd2, 1'b1);
      apply("R4 BP -> SS", 8'h8B, 3'd1, 6'b0, 4'd5, 2'd1, 1'b0);
      apply("R4 disp -> DS", 8'h8B, 3'd1, 6'b0, 4'd9, 2'd0, 1'b0);
      apply("R5 CX 16-bit err", 8'h8B, 3'd1, 6'b0, 4'd1, 2'd0, 1'b0);
      apply("R5 DX 32-bit ok", 8'h8B, 3'd1, 6'b0, 4'd2, 2'd1, 1'b0);
      apply("R6 IP multi ok", 8'h8B, 3'd1, 6'b111111, 4'd8, 2'd1, 1'b0);
      apply("R6 IP long", 8'h8B, 3'd1, 6'b0, 4'd8, 2'd2, 1'b1);
      apply("R7 long SS ovr ignored", 8'h8B, 3'd1, 6'b000100, 4'd3, 2'd2, 1'b1);
      apply("R7 long GS kept", 8'h8B, 3'd1, 6'b100000, 4'd3, 2'd2, 1'b1);
      apply("R7 long default AX16", 8'h8B, 3'd1, 6'b0, 4'd0, 2'd0, 1'b1);
      apply("R8 bad code", 8'h8B, 3'd1, 6'b0, 4'd12, 2'd1, 1'b0);
      apply("R9 FS override", 8'h8B, 3'd1, 6'b010000, 4'd4, 2'd1, 1'b0);
      apply("R9 CS override on nonstring DI", 8'h8B, 3'd1, 6'b000010, 4'd7, 2'd1, 1'b0);

      // R11: outputs held while no strobe
      held = {out_err, out_seg};
      base_reg = 4'd13;
      @(negedge clk);
      @(negedge clk);
      check("R11 hold without strobe", {out_err, out_seg}, held);
      check("R11 done low", {3'b0, out_done}, 4'd0);

      for (int k = 0; k < 1500; k++) begin
         logic [7:0] op;
         logic [5:0] m;
         int sel;
         sel = $urandom_range(0, 3);
         case (sel)
            0: op = 8'h6A + 8'($urandom_range(0, 7));
            1: op = 8'hA2 + 8'($urandom_range(0, 15));
            default: op = 8'($urandom);
         endcase
         m = ($urandom_range(0, 1) == 0) ? 6'(1 << $urandom_range(0, 5)) : 6'($urandom);
         if ($urandom_range(0, 3) == 0) m = '0;
         apply("R1-random mix", op, 3'($urandom_range(1, 3)), m, 4'($urandom),
               2'($urandom_range(0, 2)), 1'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule